// File: doc/BRIEF.md
# UART Receive Buffer with Per-Frame Status

This block sits between a UART receive shift stage and a processor-style read interface. Each completed frame arrives as eight data bits, the first stop bit and the parity bit, marked by a one-cycle valid strobe. The block keeps up to two unread characters in a small queue. A third completed character may wait in the shift stage until an entry frees up. Each stored character carries its own framing, overrun and parity error flags, so software sees the flags that belong to the character at the head of the queue.

The control is a five-state machine over queue occupancy:
- `S_EMPTY` holds nothing.
- `S_ONE` and `S_TWO` hold one or two characters.
- `S_FULL` holds two characters plus one waiting in the shift stage.
- `S_DRAIN` holds one character while the waiting character moves into the queue.

Named transitions:
- accept: a frame is pushed in `S_EMPTY`, `S_ONE` or `S_TWO` (with a read in `S_TWO`).
- park: a frame arrives in `S_TWO` with no read, and the machine goes to `S_FULL`.
- release: a read in `S_FULL`, and the machine goes to `S_DRAIN`.
- settle: `S_DRAIN` pushes the waiting character and goes to `S_ONE` or `S_TWO`, or stays in the holding states if another frame lands.
- consume: a read lowers occupancy.
- flush: receiver enable is low, and the machine goes to `S_EMPTY` from any state.

A start-bit strobe that arrives in `S_FULL` marks an overrun. The overrun flag is attached to the waiting character when that character enters the queue.

Top module: `uart_rx_buffer`

## Requirements
- R1: `rx_done` is 1 in the cycle after a frame is accepted while enabled, stays 1 while any unread character is queued, and is 0 when the queue is empty.
- R2: When `rx_en` is 0 at a clock edge, every queued and waiting character and any pending overrun are discarded, so `rx_done` is 0 afterwards. Frames presented while `rx_en` is 0 are not stored.
- R3: `irq` equals `irq_en` AND `rx_done`. It therefore stays high until data reads empty the queue. No error flag affects `irq`.
- R4: Characters are read oldest first. A one-cycle `rd_stb` pulse removes the head character, and `rd_data` then shows the next one. When the queue is empty, `rd_data` and all status bits read 0.
- R5: `st_frm_err`, `st_overrun` and `st_par_err` always show the flags stored with the character currently on `rd_data`.
- R6: The framing error flag is the inverse of the first stop bit: `frm_stop`=1 gives 0, and `frm_stop`=0 gives 1.
- R7: A frame that completes while two characters are queued waits in the shift stage. It enters the queue on the cycle after a read and is read third.
- R8: A `start_det` pulse in the full condition (two queued plus one waiting) sets the overrun flag on the waiting character. A start pulse with only two characters queued, and every later character, carry overrun 0.
- R9: With `par_chk_en`=1, the parity error is the XOR of the data bits XOR `frm_par` XOR `par_odd`. Here `par_odd`=0 means even parity and 1 means odd. With `par_chk_en`=0, the parity error is 0.
- R10: A frame that completes while a character is already waiting replaces the waiting character, and the replaced character is lost.
- R11: An `rd_stb` pulse while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes |
| irq_en | input | 1 | Receive-complete interrupt enable |
| par_chk_en | input | 1 | Parity checking on |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| start_det | input | 1 | Start bit detected strobe |
| frm_valid | input | 1 | Completed frame strobe |
| frm_data | input | 8 | Frame data bits |
| frm_stop | input | 1 | First stop bit as received |
| frm_par | input | 1 | Parity bit as received |
| rd_stb | input | 1 | Data read strobe; pops the head |
| rd_data | output | 8 | Head character |
| st_frm_err | output | 1 | Framing error of the head character |
| st_overrun | output | 1 | Overrun flag of the head character |
| st_par_err | output | 1 | Parity error of the head character |
| rx_done | output | 1 | Unread data present |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The bench fills the queue past two characters and then reads back. A design that drops the waiting character, or moves it early, returns the wrong third byte. It raises a start strobe both with two characters queued and in the full condition. A design that decides overrun on the wrong occupancy, or leaves the flag set, marks the wrong character. It also replaces a waiting character and flushes with an overrun pending, checking that the lost byte is gone and that the stale overrun flag does not reach the next character. Parity is checked in both senses with correct and incorrect parity bits, which catches an inverted or swapped odd/even selection.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    localparam int DATA_W    = 8;
    localparam int BUF_DEPTH = 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fe;
        logic              ovr;
        logic              pe;
    } rxb_entry_t;

    typedef enum logic [2:0] {
        S_EMPTY = 3'd0,
        S_ONE   = 3'd1,
        S_TWO   = 3'd2,
        S_FULL  = 3'd3,
        S_DRAIN = 3'd4
    } rxb_state_t;
endpackage

// File: rtl/rxb_parity_chk.sv
module rxb_parity_chk #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         par_bit,
    input  logic         chk_en,
    input  logic         odd_mode,
    output logic         err
);
    // even: mismatch of data XOR with parity bit; odd: match
    always_comb err = chk_en & ((^data) ^ par_bit ^ odd_mode);
endmodule

// File: rtl/rxb_store.sv
module rxb_store
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  logic       pop,
    input  rxb_entry_t wr_entry,
    output rxb_entry_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    rxb_entry_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_entry;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)
                occ <= occ + 1'b1;
            else if (pop && !push)
                occ <= occ - 1'b1;
        end
    end

    always_comb head = mem[rd_ptr];

    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> (occ < (PW+1)'(DEPTH)));

    a_r11_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (occ != '0));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              irq_en,
    input  logic              par_chk_en,
    input  logic              par_odd,
    input  logic              start_det,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_stop,
    input  logic              frm_par,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              st_frm_err,
    output logic              st_overrun,
    output logic              st_par_err,
    output logic              rx_done,
    output logic              irq
);
    rxb_state_t state, state_nx;
    rxb_entry_t hold_q, new_entry, wr_entry, head;
    logic       ovr_pend_q;
    logic       pe_w, rd_ok, push, pop, push_hold, load_hold;

    rxb_parity_chk #(.W(DATA_W)) u_par (
        .data(frm_data), .par_bit(frm_par), .chk_en(par_chk_en),
        .odd_mode(par_odd), .err(pe_w)
    );

    always_comb begin
        new_entry      = '0;
        new_entry.data = frm_data;
        new_entry.fe   = ~frm_stop;
        new_entry.pe   = pe_w;
        wr_entry       = new_entry;
        if (push_hold) begin
            wr_entry     = hold_q;
            wr_entry.ovr = ovr_pend_q;
        end
    end

    rxb_store #(.DEPTH(BUF_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push), .pop(pop),
        .wr_entry(wr_entry), .head(head)
    );

    // next-state and control decode
    always_comb begin
        rd_ok     = rd_stb && (state != S_EMPTY);
        state_nx  = state;
        push      = 1'b0;
        pop       = rd_ok;
        push_hold = 1'b0;
        load_hold = 1'b0;
        unique case (state)
            S_EMPTY: if (frm_valid) begin
                push     = 1'b1;
                state_nx = S_ONE;
            end
            S_ONE: begin
                if (frm_valid) begin
                    push     = 1'b1;
                    state_nx = rd_ok ? S_ONE : S_TWO;
                end else if (rd_ok) begin
                    state_nx = S_EMPTY;
                end
            end
            S_TWO: begin
                if (frm_valid && rd_ok) begin
                    push = 1'b1;
                end else if (frm_valid) begin
                    load_hold = 1'b1;
                    state_nx  = S_FULL;
                end else if (rd_ok) begin
                    state_nx = S_ONE;
                end
            end
            S_FULL: begin
                load_hold = frm_valid;
                if (rd_ok) state_nx = S_DRAIN;
            end
            S_DRAIN: begin
                push      = 1'b1;
                push_hold = 1'b1;
                load_hold = frm_valid;
                if (frm_valid) state_nx = rd_ok ? S_DRAIN : S_FULL;
                else           state_nx = rd_ok ? S_ONE : S_TWO;
            end
            default: state_nx = S_EMPTY;
        endcase
        if (!rx_en) begin
            state_nx  = S_EMPTY;
            push      = 1'b0;
            pop       = 1'b0;
            load_hold = 1'b0;
        end
    end

    // state register and shift-stage holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_EMPTY;
            hold_q     <= '0;
            ovr_pend_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (load_hold) hold_q <= new_entry;
            if (!rx_en)
                ovr_pend_q <= 1'b0;
            else if (state == S_FULL && start_det)
                ovr_pend_q <= 1'b1;
            else if (push_hold)
                ovr_pend_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        rx_done    = (state != S_EMPTY);
        irq        = irq_en & rx_done;
        rd_data    = rx_done ? head.data : '0;
        st_frm_err = rx_done & head.fe;
        st_overrun = rx_done & head.ovr;
        st_par_err = rx_done & head.pe;
    end

    a_r1_frame_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && frm_valid) |=> rx_done);

    a_r2_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_done);

    a_r3_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rx_en && !rd_stb) |=> (irq || !irq_en));

    a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && !rd_stb) |=>
            ($stable(rd_data) && $stable(st_frm_err) && $stable(st_overrun) && $stable(st_par_err)));
endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
    import uart_rxb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, irq_en = 1'b0, par_chk_en = 1'b0, par_odd = 1'b0;
    logic start_det = 1'b0, frm_valid = 1'b0, frm_stop = 1'b1, frm_par = 1'b0, rd_stb = 1'b0;
    logic [7:0] frm_data = '0;
    logic [7:0] rd_data;
    logic st_frm_err, st_overrun, st_par_err, rx_done, irq;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    rxb_entry_t exp_q[$];

    always #5 clk = ~clk;

    uart_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_en(irq_en),
        .par_chk_en(par_chk_en), .par_odd(par_odd), .start_det(start_det),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_stop(frm_stop),
        .frm_par(frm_par), .rd_stb(rd_stb), .rd_data(rd_data),
        .st_frm_err(st_frm_err), .st_overrun(st_overrun), .st_par_err(st_par_err),
        .rx_done(rx_done), .irq(irq)
    );

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // driver: mode 0 = not expected stored, 1 = append, 2 = replace waiting entry
    task automatic send(logic [7:0] d, logic stop, logic par, int mode);
        rxb_entry_t e;
        e.data = d;
        e.fe   = ~stop;
        e.ovr  = 1'b0;
        e.pe   = par_chk_en & ((^d) ^ par ^ par_odd);
        @(negedge clk);
        frm_data = d; frm_stop = stop; frm_par = par; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        if (mode == 1) exp_q.push_back(e);
        else if (mode == 2) exp_q[$] = e;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
    endtask

    // monitor: compare head against scoreboard, then consume it
    task automatic read_chk(string req);
        rxb_entry_t e;
        if (exp_q.size() == 0) begin
            check_eq(req, "scoreboard empty", 1, 0);
            return;
        end
        e = exp_q.pop_front();
        check_eq(req, "rx_done before read", {31'b0, rx_done}, 1);
        check_eq(req, "data", {24'b0, rd_data}, {24'b0, e.data});
        check_eq(req, "fe", {31'b0, st_frm_err}, {31'b0, e.fe});
        check_eq(req, "ovr", {31'b0, st_overrun}, {31'b0, e.ovr});
        check_eq(req, "pe", {31'b0, st_par_err}, {31'b0, e.pe});
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog all-R act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R3 R4 reset state
        check_eq("R1", "reset rx_done", {31'b0, rx_done}, 0);
        check_eq("R3", "reset irq", {31'b0, irq}, 0);
        check_eq("R4", "reset data", {24'b0, rd_data}, 0);

        rx_en = 1'b1; irq_en = 1'b1;
        send(8'hA5, 1'b1, 1'b0, 1);
        check_eq("R1", "flag after frame", {31'b0, rx_done}, 1);
        check_eq("R3", "irq after frame", {31'b0, irq}, 1);
        read_chk("R4");
        check_eq("R1", "flag after drain", {31'b0, rx_done}, 0);
        check_eq("R3", "irq after drain", {31'b0, irq}, 0);

        // R11 read on empty queue ignored
        @(negedge clk); rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
        check_eq("R11", "flag after empty read", {31'b0, rx_done}, 0);
        send(8'h11, 1'b1, 1'b0, 1);
        read_chk("R11");

        // R6 framing error from first stop bit
        send(8'h3C, 1'b0, 1'b0, 1);
        read_chk("R6");

        // R9 parity even then odd, R4 ordering of two
        par_chk_en = 1'b1; par_odd = 1'b0;
        send(8'h01, 1'b1, 1'b1, 1);
        send(8'h01, 1'b1, 1'b0, 1);
        check_eq("R3", "irq with two queued", {31'b0, irq}, 1);
        read_chk("R9");
        check_eq("R3", "irq after one of two read", {31'b0, irq}, 1);
        read_chk("R9");
        check_eq("R3", "irq after both read", {31'b0, irq}, 0);
        par_odd = 1'b1;
        send(8'h03, 1'b1, 1'b0, 1);
        send(8'h03, 1'b1, 1'b1, 1);
        read_chk("R9");
        read_chk("R9");
        par_chk_en = 1'b0;
        send(8'h07, 1'b1, 1'b1, 1);
        read_chk("R9");

        // R7 third frame waits; start with only two queued is no overrun (R8)
        send(8'hB0, 1'b1, 1'b0, 1);
        send(8'hB1, 1'b1, 1'b0, 1);
        pulse_start();
        send(8'hB2, 1'b1, 1'b0, 1);
        read_chk("R7");
        read_chk("R7");
        read_chk("R8");
        check_eq("R7", "empty after three", {31'b0, rx_done}, 0);

        // R8 overrun in full condition, R10 replacement of waiting frame
        send(8'hF0, 1'b1, 1'b0, 1);
        send(8'hF1, 1'b1, 1'b0, 1);
        send(8'hF2, 1'b1, 1'b0, 1);
        pulse_start();
        send(8'hF3, 1'b1, 1'b0, 2);
        exp_q[$].ovr = 1'b1;
        read_chk("R5");
        read_chk("R8");
        read_chk("R10");
        send(8'hF4, 1'b1, 1'b0, 1);
        read_chk("R8");

        // R2 flush with held frame and pending overrun
        send(8'hC0, 1'b1, 1'b0, 1);
        send(8'hC1, 1'b1, 1'b0, 1);
        send(8'hC2, 1'b1, 1'b0, 1);
        pulse_start();
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk);
        check_eq("R2", "flag after flush", {31'b0, rx_done}, 0);
        check_eq("R2", "irq after flush", {31'b0, irq}, 0);
        exp_q.delete();
        send(8'h55, 1'b1, 1'b0, 0);
        check_eq("R2", "frame ignored while disabled", {31'b0, rx_done}, 0);
        rx_en = 1'b1;
        send(8'h77, 1'b1, 1'b0, 1);
        read_chk("R2");

        // R3 interrupt disabled
        irq_en = 1'b0;
        send(8'h99, 1'b0, 1'b0, 1);
        check_eq("R3", "irq masked", {31'b0, irq}, 0);
        check_eq("R1", "flag with irq masked", {31'b0, rx_done}, 1);
        read_chk("R5");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule